// File: doc/BRIEF.md
# Counting Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt output towards a processor. It has a small register window for control. Each line has a latched level bit, which is set when the line rises and cleared when it falls. Each line also has an enable bit. A counter holds the number of lines that are latched and enabled at the same moment. The counter is not recomputed from the masks. It is adjusted by one on every event that changes that number.

Software reads two values: the pending count, and the lowest-numbered line that is latched and enabled. Software turns one line on or off by writing that line's index to a command offset. A third command offset drops every latched level in one write and keeps the enable mask as it is. A second, fast-class output is driven from its own enable mask. That mask has no write path, so the output stays low.

Each cycle, line edges are applied before register commands, so a command always sees the latched levels as that same cycle's edges left them. The two outputs and the read data are registered. An access to an offset that is not defined raises an error pulse.

Top module: `irq_count_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `irq_o`, `fiq_o`, `bus_rdata` and `bus_err` are 0. Reset also clears the latched levels, the enable mask and the pending count.
- R2: A rising edge on `src_in[n]` when level bit n is clear sets level bit n. If line n is enabled, the pending count goes up by one. Offset 0x000 reads the pending count.
- R3: A falling edge on `src_in[n]` when level bit n is set clears level bit n. If line n is enabled, the pending count goes down by one. A line that holds its level changes nothing.
- R4: A read of offset 0x004 returns the lowest index n for which level bit n and enable bit n are both 1. If no line qualifies, it returns 0.
- R5: A write of value v to offset 0x010 uses n = v[4:0] and ignores v[31:5]. If line n is disabled, the write sets enable bit n, and the count goes up by one when level bit n is 1. If line n is already enabled, the write changes nothing.
- R6: A write of value v to offset 0x00C uses n = v[4:0]. If line n is enabled, the write clears enable bit n, and the count goes down by one when level bit n is 1. If line n is already disabled, the write changes nothing.
- R7: A write to offset 0x008 zeroes the pending count and all level bits and leaves the enable mask unchanged. A line that stays high is not latched again until it falls and rises once more.
- R8: At each clock edge, `irq_o` takes the value of OR(level AND enable) as it stood before that edge, so it follows any state change one cycle later.
- R9: `fiq_o` is 0 at all times.
- R10: The following accesses are undefined:
  - a read at any offset other than 0x000 or 0x004;
  - a write at any offset other than 0x008, 0x00C or 0x010.

  An undefined access changes no state and returns read data 0. It raises `bus_err` for exactly the one cycle after it.
- R11: When a line edge and a command write fall in the same cycle, the edge is applied first. A rise on an enabled line plus a disable of that line leaves the count unchanged. A rise plus a clear-all leaves the level clear.
- R12: `bus_rdata` is registered. It shows the value read in the cycle after `bus_ren`, using the state from before that edge. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Interrupt request lines, line n on bit n |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset inside the 4 KiB window |
| bus_wdata | input | 32 | Write data (line index for enable and disable) |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an undefined access |
| irq_o | output | 1 | Combined normal interrupt |
| fiq_o | output | 1 | Combined fast interrupt |

## Verification
The checker holds four properties on every cycle:
- the incrementally kept count always equals the population of (level AND enable);
- `irq_o` trails that OR term by exactly one cycle;
- `fiq_o` never rises;
- a clear-all leaves levels and count at zero and the mask stable, and an error pulse comes only after an access and carries zero read data.

Some behaviours only the bench's scenarios can show, because they depend on command sequences:
- the lowest-index lookup and its zero result when nothing is pending;
- commands that find their line already in the requested state and change nothing;
- ignored high index bits;
- the edge-before-write ordering in a shared cycle;
- the rule that a cleared line which stays high is not latched again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [2:0] {
        WC_NONE,
        WC_CLEAR_ALL,
        WC_DISABLE,
        WC_ENABLE,
        WC_BAD
    } wr_cmd_t;

    typedef enum logic [1:0] {
        RS_NONE,
        RS_COUNT,
        RS_INDEX,
        RS_BAD
    } rd_sel_t;

    localparam int unsigned OFS_COUNT = 'h000;
    localparam int unsigned OFS_INDEX = 'h004;
    localparam int unsigned OFS_CLEAR = 'h008;
    localparam int unsigned OFS_DIS   = 'h00C;
    localparam int unsigned OFS_EN    = 'h010;

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src;
    end

    assign rise = src & ~prev_q;
    assign fall = ~src & prev_q;
endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          wen,
    input  logic          ren,
    input  logic [AW-1:0] addr,
    output wr_cmd_t       wr_cmd,
    output rd_sel_t       rd_sel
);
    localparam logic [AW-1:0] A_COUNT = AW'(OFS_COUNT);
    localparam logic [AW-1:0] A_INDEX = AW'(OFS_INDEX);
    localparam logic [AW-1:0] A_CLEAR = AW'(OFS_CLEAR);
    localparam logic [AW-1:0] A_DIS   = AW'(OFS_DIS);
    localparam logic [AW-1:0] A_EN    = AW'(OFS_EN);

    always_comb begin
        wr_cmd = WC_NONE;
        if (wen) begin
            unique case (addr)
                A_CLEAR: wr_cmd = WC_CLEAR_ALL;
                A_DIS:   wr_cmd = WC_DISABLE;
                A_EN:    wr_cmd = WC_ENABLE;
                default: wr_cmd = WC_BAD;
            endcase
        end
    end

    always_comb begin
        rd_sel = RS_NONE;
        if (ren) begin
            unique case (addr)
                A_COUNT: rd_sel = RS_COUNT;
                A_INDEX: rd_sel = RS_INDEX;
                default: rd_sel = RS_BAD;
            endcase
        end
    end
endmodule

// File: rtl/irq_count_ctrl.sv
module irq_count_ctrl
    import irqc_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 12,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            bus_wen,
    input  logic            bus_ren,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_err,
    output logic            irq_o,
    output logic            fiq_o
);
    localparam int IW = $clog2(NSRC);
    localparam int CW = $clog2(NSRC + 1);

    logic [NSRC-1:0] level_q, level_n;
    logic [NSRC-1:0] en_q, en_n;
    logic [NSRC-1:0] fiq_en_q;
    logic [CW-1:0]   cnt_q, cnt_n;
    logic [NSRC-1:0] rise, fall;
    logic [IW-1:0]   low_idx;
    logic [IW-1:0]   widx;
    logic            widx_ok;
    wr_cmd_t         wr_cmd;
    rd_sel_t         rd_sel;
    logic [DW-1:0]   rd_val;
    logic            bad_acc;
    logic            unused_wdata_hi;

    irqc_edge #(.N(NSRC)) u_edge (
        .clk (clk),
        .rst_n (rst_n),
        .src (src_in),
        .rise (rise),
        .fall (fall)
    );

    irqc_lowest #(.N(NSRC), .IW(IW)) u_low (
        .vec (level_q & en_q),
        .idx (low_idx)
    );

    irqc_decode #(.AW(AW)) u_dec (
        .wen (bus_wen),
        .ren (bus_ren),
        .addr (bus_addr),
        .wr_cmd (wr_cmd),
        .rd_sel (rd_sel)
    );

    assign widx            = bus_wdata[IW-1:0];
    assign widx_ok         = int'(widx) < NSRC;
    assign unused_wdata_hi = ^bus_wdata[DW-1:IW];

    // Edges first, then the decoded command on the result.
    always_comb begin
        level_n = level_q;
        en_n    = en_q;
        cnt_n   = cnt_q;
        for (int i = 0; i < NSRC; i++) begin
            if (rise[i] && !level_n[i]) begin
                level_n[i] = 1'b1;
                if (en_q[i]) cnt_n = cnt_n + 1'b1;
            end else if (fall[i] && level_n[i]) begin
                level_n[i] = 1'b0;
                if (en_q[i]) cnt_n = cnt_n - 1'b1;
            end
        end
        unique case (wr_cmd)
            WC_CLEAR_ALL: begin
                level_n = '0;
                cnt_n   = '0;
            end
            WC_DISABLE: begin
                if (widx_ok && en_n[widx]) begin
                    en_n[widx] = 1'b0;
                    if (level_n[widx]) cnt_n = cnt_n - 1'b1;
                end
            end
            WC_ENABLE: begin
                if (widx_ok && !en_n[widx]) begin
                    en_n[widx] = 1'b1;
                    if (level_n[widx]) cnt_n = cnt_n + 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (rd_sel)
            RS_COUNT: rd_val = DW'(cnt_q);
            RS_INDEX: rd_val = DW'(low_idx);
            default:  rd_val = '0;
        endcase
    end

    assign bad_acc = (wr_cmd == WC_BAD) || (rd_sel == RS_BAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q  <= '0;
            en_q     <= '0;
            fiq_en_q <= '0;
            cnt_q    <= '0;
        end else begin
            level_q  <= level_n;
            en_q     <= en_n;
            fiq_en_q <= fiq_en_q;
            cnt_q    <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            fiq_o     <= 1'b0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            irq_o     <= |(level_q & en_q);
            fiq_o     <= |(level_q & fiq_en_q);
            bus_rdata <= rd_val;
            bus_err   <= bad_acc;
        end
    end
endmodule

// File: rtl/irq_count_ctrl_chk.sv
module irq_count_ctrl_chk #(
    parameter int NSRC = 32,
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int CW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wen,
    input logic            bus_ren,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_rdata,
    input logic            bus_err,
    input logic            irq_o,
    input logic            fiq_o,
    input logic [NSRC-1:0] level_q,
    input logic [NSRC-1:0] en_q,
    input logic [CW-1:0]   cnt_q
);
    // R2 R3 R5 R6: the incremental count matches the pending population
    a_r2_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) == $countones(level_q & en_q));

    a_r8_irq_lags: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(|(level_q & en_q)));

    a_r9_fiq_low: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_o);

    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == AW'('h008)) |=> (level_q == '0 && cnt_q == '0 && $stable(en_q)));

    a_r10_err_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> $past(bus_wen || bus_ren));

    a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == '0);
endmodule

bind irq_count_ctrl irq_count_ctrl_chk #(
    .NSRC(NSRC), .AW(AW), .DW(DW), .CW(CW)
) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .bus_wen (bus_wen),
    .bus_ren (bus_ren),
    .bus_addr (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_err (bus_err),
    .irq_o (irq_o),
    .fiq_o (fiq_o),
    .level_q (level_q),
    .en_q (en_q),
    .cnt_q (cnt_q)
);

// File: tb/irq_count_ctrl_bench.sv
module irq_count_ctrl_bench;
    localparam time HALF = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_wen = 1'b0;
    logic        bus_ren = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_o;
    logic        fiq_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // behavioural reference state
    bit [31:0] m_lvl, m_en, m_prev, m_rdata;
    int        m_cnt;
    bit        m_irq, m_err;

    always #HALF clk = ~clk;

    irq_count_ctrl u_irq_count_ctrl (
        .clk (clk),
        .rst_n (rst_n),
        .src_in (src_in),
        .bus_wen (bus_wen),
        .bus_ren (bus_ren),
        .bus_addr (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err (bus_err),
        .irq_o (irq_o),
        .fiq_o (fiq_o)
    );

    function automatic int lowest(bit [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic model_edge();
        bit [31:0] nl = m_lvl;
        bit [31:0] ne = m_en;
        int        nc = m_cnt;
        int        n  = int'(bus_wdata[4:0]);
        bit        bad = 1'b0;
        bit [31:0] rv = '0;
        if (!rst_n) begin
            m_lvl = '0; m_en = '0; m_prev = '0; m_cnt = 0;
            m_irq = 0; m_err = 0; m_rdata = '0;
            return;
        end
        if (bus_ren) begin
            if (bus_addr == 12'h000)      rv = m_cnt;
            else if (bus_addr == 12'h004) rv = lowest(m_lvl & m_en);
            else                          bad = 1'b1;
        end
        if (bus_wen && !(bus_addr inside {12'h008, 12'h00C, 12'h010})) bad = 1'b1;
        m_irq   = |(m_lvl & m_en);
        m_rdata = rv;
        m_err   = bad;
        for (int i = 0; i < 32; i++) begin
            if (src_in[i] && !m_prev[i] && !nl[i]) begin
                nl[i] = 1; if (ne[i]) nc++;
            end else if (!src_in[i] && m_prev[i] && nl[i]) begin
                nl[i] = 0; if (ne[i]) nc--;
            end
        end
        m_prev = src_in;
        if (bus_wen && bus_addr == 12'h008) begin
            nl = '0; nc = 0;
        end else if (bus_wen && bus_addr == 12'h00C && ne[n]) begin
            ne[n] = 0; if (nl[n]) nc--;
        end else if (bus_wen && bus_addr == 12'h010 && !ne[n]) begin
            ne[n] = 1; if (nl[n]) nc++;
        end
        m_lvl = nl; m_en = ne; m_cnt = nc;
    endtask

    task automatic cmp(string tag, string what, logic [31:0] got, logic [31:0] exp);
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // one clock: model at the edge, compare at the following falling edge
    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        vectors++;
        cmp(tag, "irq_o", 32'(irq_o), 32'(m_irq));
        cmp({tag, "/R9"}, "fiq_o", 32'(fiq_o), 32'd0);
        cmp({tag, "/R12"}, "bus_rdata", bus_rdata, m_rdata);
        cmp({tag, "/R10"}, "bus_err", 32'(bus_err), 32'(m_err));
    endtask

    task automatic idle(string tag, int n = 1);
        bus_wen = 0; bus_ren = 0;
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
        bus_wen = 1; bus_ren = 0; bus_addr = a; bus_wdata = d;
        tick(tag);
        bus_wen = 0;
    endtask

    // read and also check against a literal from the requirement
    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        bus_ren = 1; bus_wen = 0; bus_addr = a;
        tick(tag);
        bus_ren = 0;
        vectors++;
        cmp(tag, "read", bus_rdata, exp);
    endtask

    task automatic set_src(int n, bit v);
        src_in[n] = v;
    endtask

    initial begin
        @(negedge clk);
        idle("R1", 2);
        vectors++;
        cmp("R1", "reset irq", 32'(irq_o), 32'd0);
        rst_n = 1;
        idle("R1", 1);
        rd(12'h000, 0, "R1");
        rd(12'h004, 0, "R4");

        // R5: enable lines 3, 7, 20
        wr(12'h010, 3, "R5");
        wr(12'h010, 7, "R5");
        wr(12'h010, 20, "R5");
        // R2: raise lines 7, 3, 12
        set_src(7, 1); idle("R2");
        set_src(3, 1); set_src(12, 1); idle("R2", 2);
        rd(12'h000, 2, "R2");
        rd(12'h004, 3, "R4");
        vectors++; cmp("R8", "irq high", 32'(irq_o), 32'd1);

        // R5: upper bits ignored, then a repeat enable changes nothing
        wr(12'h010, 32'hFFFF_FFEC, "R5");
        rd(12'h000, 3, "R5");
        wr(12'h010, 12, "R5");
        rd(12'h000, 3, "R5");

        // R3: steady levels, then a fall
        idle("R3", 4);
        rd(12'h000, 3, "R3");
        set_src(3, 0); idle("R3");
        rd(12'h000, 2, "R3");
        rd(12'h004, 7, "R4");

        // R6: disable 7, twice
        wr(12'h00C, 7, "R6");
        rd(12'h000, 1, "R6");
        rd(12'h004, 12, "R6");
        wr(12'h00C, 32'h0000_0107, "R6");
        rd(12'h000, 1, "R6");

        // R7: clear all, line 12 stays high, not re-latched
        wr(12'h008, 0, "R7");
        idle("R7", 3);
        rd(12'h000, 0, "R7");
        vectors++; cmp("R7", "irq low", 32'(irq_o), 32'd0);
        rd(12'h004, 0, "R4");
        set_src(12, 0); idle("R7");
        set_src(12, 1); idle("R7", 2);
        rd(12'h000, 1, "R7");

        // R10: undefined accesses
        rd(12'h008, 0, "R10");
        wr(12'h000, 5, "R10");
        rd(12'h7FC, 0, "R10");
        wr(12'h014, 5, "R10");
        idle("R10");
        rd(12'h000, 1, "R10");
        rd(12'h004, 12, "R10");

        // R11: edge and write in one cycle
        set_src(20, 1); wr(12'h00C, 20, "R11");
        rd(12'h000, 1, "R11");
        wr(12'h010, 20, "R11");
        rd(12'h000, 2, "R11");
        set_src(5, 1); wr(12'h008, 0, "R11");
        wr(12'h010, 5, "R11");
        rd(12'h000, 0, "R11");

        idle("R8", 3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired R1 got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule